// File: doc/BRIEF.md
# Bus Wait-State Ready Generator

This block drives the ready line that a processor bus cycle samples to decide whether it must stretch the cycle with wait states. A chain of single-bit stages is held at zero while no bus cycle is running. Once a cycle starts, a constant 1 enters the first stage and moves one stage further on every clock. A small binary select input picks which stage feeds the registered ready output. A larger select value therefore delays ready by more clocks, and each extra clock of delay adds one wait state to the cycle.

Typical use: the memory or I/O decode logic raises `cyc_active` for the whole of a bus cycle and sets `wait_sel` to the number of wait states the selected device needs. The ready output goes to the ready input of the clock generator. While ready is low the processor repeats its wait state. When the cycle ends, `cyc_active` drops, which clears the chain and returns ready to 0 in time for the next cycle.

Top module: `wsg_ready_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, `rdy` is 0 after that edge.
- R2: After any clock edge at which `cyc_active` is 0, `rdy` is 0, whatever `wait_sel` is.
- R3: With `wait_sel` = 0, `rdy` is 1 after the first clock edge at which `cyc_active` is sampled high. No wait state is inserted.
- R4: `wait_sel` is an unsigned binary count n from 0 to 7. When `cyc_active` is held high and `wait_sel` is held stable, `rdy` stays 0 after the first n edges of the cycle and becomes 1 after edge n+1. The cycle therefore sees exactly n extra low-ready clocks compared with n = 0.
- R5: Once `rdy` is 1, it stays 1 on every following edge for as long as `cyc_active` stays high and `wait_sel` does not change.
- R6: After `cyc_active` falls, `rdy` is 0 after the next edge. A new cycle that begins after even a single idle clock counts its full n+1 edges again, with no carry-over from the previous cycle.
- R7: Changes to `wait_sel` while `cyc_active` is 0 have no effect: `rdy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cyc_active | input | 1 | High for the duration of a bus cycle; low clears the delay chain |
| wait_sel | input | 3 | Number of wait states, unsigned binary 0 to 7 |
| rdy | output | 1 | Registered ready for the clock generator; low holds the cycle in wait states |

## Verification
The delay state is a thermometer of ones that fills from the first stage. A stage that is stuck, or filled too early or too late, shows up at `rdy` as a wait-state count that is off by one or more. The error appears in the first bus cycle whose `wait_sel` selects that stage, within at most eight clocks of the cycle start. A clear that fails leaves ones behind, so the following cycle shows up with too few wait states, or with `rdy` already high one clock after `cyc_active` falls. The bench counts the low-ready clocks of every cycle for every select value, including back-to-back cycles separated by one idle clock.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  // Default number of delay stages; one stage per selectable wait state plus the zero-wait stage.
  localparam int unsigned WSG_DEFAULT_STAGES = 8;
endpackage

// File: rtl/wsg_shift_chain.sv
module wsg_shift_chain #(
  parameter int unsigned DEPTH = wsg_pkg::WSG_DEFAULT_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill,
  output logic [DEPTH-1:0] taps,
  output logic [DEPTH-1:0] taps_next
);
  // Stage i holds 1 once fill has been high for i+1 consecutive edges.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || !fill) taps[i] <= 1'b0;
        else              taps[i] <= 1'b1;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || !fill) taps[i] <= 1'b0;
        else              taps[i] <= taps[i-1];
      end
    end
  end

  // Contents the chain will hold after the coming edge if fill stays high.
  if (DEPTH > 1) begin : g_next_multi
    assign taps_next = {taps[DEPTH-2:0], 1'b1};
  end else begin : g_next_single
    assign taps_next = 1'b1;
  end

  // R4: the chain is always a thermometer of ones filled from stage 0.
  p_thermometer_r4: assert property (@(posedge clk) disable iff (rst)
    ((taps + DEPTH'(1)) & taps) == '0);

  // R4: a filling chain has its first stage set on the next edge.
  p_head_fill_r4: assert property (@(posedge clk) disable iff (rst)
    fill |=> taps[0]);

  // R6: an idle edge empties the whole chain.
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !fill |=> (taps == '0));
endmodule

// File: rtl/wsg_tap_mux.sv
module wsg_tap_mux #(
  parameter int unsigned DEPTH = wsg_pkg::WSG_DEFAULT_STAGES,
  localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] vec,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out
);
  // Out-of-range selects (non power-of-two depth) fall back to the last stage.
  always_comb begin
    bit_out = vec[DEPTH-1];
    for (int i = 0; i < DEPTH; i++) begin
      if (sel == SEL_W'(i)) bit_out = vec[i];
    end
  end
endmodule

// File: rtl/wsg_ready_gen.sv
module wsg_ready_gen #(
  parameter int unsigned STAGES = wsg_pkg::WSG_DEFAULT_STAGES,
  localparam int unsigned SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_active,
  input  logic [SEL_W-1:0] wait_sel,
  output logic             rdy
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              tap_sel;

  wsg_shift_chain #(.DEPTH(STAGES)) i_chain (
    .clk       (clk),
    .rst       (rst),
    .fill      (cyc_active),
    .taps      (chain_q),
    .taps_next (chain_d)
  );

  // Pick from the post-edge view so that ready leaves a register of its own.
  wsg_tap_mux #(.DEPTH(STAGES)) i_mux (
    .vec     (chain_d),
    .sel     (wait_sel),
    .bit_out (tap_sel)
  );

  always_ff @(posedge clk) begin
    if (rst || !cyc_active) rdy <= 1'b0;
    else                    rdy <= tap_sel;
  end

  // R1: reset forces ready low.
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !rdy);

  // R2: an idle edge always leaves ready low.
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !cyc_active |=> !rdy);

  // R3: zero wait states give ready on the first active edge.
  p_zero_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_active && wait_sel == '0) |=> rdy);

  // R5: ready never drops mid-cycle under a steady select.
  p_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
    (rdy && cyc_active && $stable(wait_sel)) |=> rdy);

  // R4: ready high implies the chosen stage has filled.
  p_rdy_matches_chain_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc_active && $stable(wait_sel) && rdy) |-> chain_q[wait_sel]);
endmodule

// File: tb/test_wsg_ready_gen.sv
module test_wsg_ready_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_active = 1'b0;
  logic [2:0] wait_sel = 3'd0;
  logic       rdy;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  wsg_ready_gen i_wsg_ready_gen (
    .clk        (clk),
    .rst        (rst),
    .cyc_active (cyc_active),
    .wait_sel   (wait_sel),
    .rdy        (rdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected ready after k active edges with n wait states (R4).
  function automatic logic exp_rdy(int k, int n);
    return (k >= n + 1);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: rdy=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // One bus cycle: n wait states, hold extra clocks after ready, then idle.
  task automatic bus_cycle(int n, int hold, int idle, bit idle_sel_noise);
    @(negedge clk);
    cyc_active = 1'b1;
    wait_sel   = 3'(n);
    for (int k = 1; k <= n + 1 + hold; k++) begin
      @(negedge clk);
      if (k <= n + 1) check((n == 0) ? "R3" : "R4", rdy, exp_rdy(k, n));
      else            check("R5", rdy, 1'b1);
    end
    cyc_active = 1'b0;
    for (int j = 0; j < idle; j++) begin
      @(negedge clk);
      check(j == 0 ? "R6" : "R2", rdy, 1'b0);
      if (idle_sel_noise) begin
        wait_sel = 3'($urandom_range(0, 7));
        @(negedge clk);
        check("R7", rdy, 1'b0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, rdy=%b expected completion", rdy);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, even with a cycle requested.
    cyc_active = 1'b1;
    wait_sel   = 3'd0;
    repeat (3) @(negedge clk);
    check("R1", rdy, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    cyc_active = 1'b0;
    @(negedge clk);
    check("R2", rdy, 1'b0);

    // Directed: every select value, separated by a single idle clock (R6).
    for (int n = 0; n < 8; n++) bus_cycle(n, 2, 1, 1'b0);
    // Directed: back-to-back maximum then zero wait.
    bus_cycle(7, 0, 1, 1'b0);
    bus_cycle(0, 0, 1, 1'b0);
    // R7: select noise while idle.
    bus_cycle(3, 1, 3, 1'b1);

    // Random cycles.
    for (int r = 0; r < 60; r++)
      bus_cycle($urandom_range(0, 7), $urandom_range(0, 4),
                $urandom_range(1, 3), 1'($urandom_range(0, 1)));

    // R1: reset in the middle of a filled cycle.
    @(negedge clk);
    cyc_active = 1'b1;
    wait_sel   = 3'd1;
    repeat (3) @(negedge clk);
    check("R4", rdy, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", rdy, 1'b0);
    rst = 1'b0;
    cyc_active = 1'b0;
    @(negedge clk);
    bus_cycle(5, 1, 1, 1'b0);

    finish_run();
  end
endmodule